// File: doc/BRIEF.md
# Thread Block Dispatcher with Residency Limits

The dispatcher takes one kernel grid at a time, described by a block count and a thread count per block. It hands the blocks out, one at a time, to a small set of multiprocessor slots. A block is placed on exactly one slot and is never split across slots. Each slot has two limits: the number of blocks resident on it at once, and the total number of threads resident on it. A block is admitted to a slot only if neither limit would be exceeded.

Each admission produces one assignment record on a valid/ready output. The record holds the slot index, the block id and the range of warps created for that block. Warps are groups of 32 consecutive thread IDs, and warp 0 of a block starts at thread 0. The warp IDs are global across the grid. A block whose thread count is not a multiple of 32 ends in a partial warp, and the record carries a lane mask for it.

Each slot has a one-cycle retire input. A pulse on it reports that one block on that slot has finished. The block's thread and block counts go back to the slot in the same cycle, so the freed room can be used for a new admission at that clock edge. When every block of the grid has been handed out and has retired, the dispatcher raises a done flag. It then accepts the next grid.

Top module: `blk_dispatch`

## Requirements
- R1: After reset, no record is valid, `launch_ready` is 1 and `grid_done` is 0.
- R2: Let W = ceil(threads_per_block / 32). A record for block b reports a warp count of W and a first warp of b*W.
- R3: The tail mask has bit i set for lane i < (threads_per_block mod 32). When threads_per_block is a multiple of 32, all 32 bits are set.
- R4: No slot ever holds more than `MAX_BLK` (8) resident blocks. For example, 64-thread blocks stop at 8 per slot, which is 512 threads.
- R5: No slot ever holds more than `MAX_THR` (1536) resident threads. This allows six 256-thread blocks, three 512-thread blocks or one 1024-thread block per slot.
- R6: Blocks are admitted in increasing id order starting at 0. The slot search starts at the slot after the one that last received a block, wraps around, and takes the first slot with room. After reset the search starts at slot 0.
- R7: A retire pulse frees its block's room in the same cycle. An admission at that clock edge may use the freed room, including on the same slot.
- R8: While `asg_valid` is 1 and `asg_ready` is 0, the record stays valid and unchanged. A new admission happens only when the record register is empty or is being accepted in that cycle.
- R9: `grid_done` is 1 exactly when a grid was launched, all of its blocks have been handed over, no block is resident, and no record is pending. `launch_ready` is 1 when no grid is active or the active grid is done.
- R10: A retire pulse on a slot with no resident block has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Grid descriptor offered |
| launch_ready | output | 1 | Dispatcher can take a grid |
| launch_blocks | input | BID_W | Number of blocks in the grid |
| launch_tpb | input | TPB_W | Threads per block, 1 to MAX_TPB |
| blk_retire | input | NUM_SM | One pulse per finished block, one bit per slot |
| asg_valid | output | 1 | Assignment record valid |
| asg_ready | input | 1 | Consumer takes the record |
| asg_sm | output | SM_W | Slot that received the block |
| asg_block | output | BID_W | Block id |
| asg_warp_first | output | WID_W | First global warp id of the block |
| asg_warp_cnt | output | WPB_W | Number of warps in the block |
| asg_tail_mask | output | WARP | Active lanes of the last warp |
| grid_done | output | 1 | Grid fully dispatched and retired |

## Verification
The interesting case is a retire pulse and an admission that land on the same slot at the same clock edge. The freed room has to be counted before the fit test for the next block. To provoke this, grids of 1024-thread blocks keep every slot full, and retire pulses arrive at random while blocks are still pending. The next block can then only go to the slot whose pulse arrives in that very cycle. A behavioural model in the bench predicts on every clock which slot, if any, receives the next block. Any admission that comes one cycle late, or on the wrong slot, shows up as a mismatch in the record.

// File: rtl/blk_dispatch.sv
module blk_dispatch #(
  parameter int NUM_SM  = 4,
  parameter int MAX_BLK = 8,
  parameter int MAX_THR = 1536,
  parameter int MAX_TPB = 1024,
  parameter int WARP    = 32,
  parameter int BID_W   = 12,
  localparam int TPB_W  = $clog2(MAX_TPB + 1),
  localparam int THR_W  = $clog2(MAX_THR + 1),
  localparam int BLK_W  = $clog2(MAX_BLK + 1),
  localparam int SM_W   = (NUM_SM > 1) ? $clog2(NUM_SM) : 1,
  localparam int LW     = $clog2(WARP),
  localparam int WPB_W  = $clog2(MAX_TPB / WARP + 1),
  localparam int WID_W  = BID_W + WPB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_valid,
  output logic              launch_ready,
  input  logic [BID_W-1:0]  launch_blocks,
  input  logic [TPB_W-1:0]  launch_tpb,
  input  logic [NUM_SM-1:0] blk_retire,
  output logic              asg_valid,
  input  logic              asg_ready,
  output logic [SM_W-1:0]   asg_sm,
  output logic [BID_W-1:0]  asg_block,
  output logic [WID_W-1:0]  asg_warp_first,
  output logic [WPB_W-1:0]  asg_warp_cnt,
  output logic [WARP-1:0]   asg_tail_mask,
  output logic              grid_done
);

  logic             active;
  logic [BID_W-1:0] total, next_bid;
  logic [TPB_W-1:0] tpb;
  logic [SM_W-1:0]  last_sm;
  logic [BLK_W-1:0] blk_cnt [NUM_SM];
  logic [THR_W-1:0] thr_cnt [NUM_SM];

  logic [BLK_W-1:0] eff_blk [NUM_SM];
  logic [THR_W-1:0] eff_thr [NUM_SM];
  logic [NUM_SM-1:0] fit;
  logic             found, admit, take, finished, no_resident;
  logic [SM_W-1:0]  pick;
  logic [TPB_W:0]   tpb_round;
  logic [WPB_W-1:0] wpb;
  logic [LW-1:0]    rem;
  logic [WARP-1:0]  tail;

  assign tpb_round = {1'b0, tpb} + (TPB_W+1)'(WARP - 1);
  assign wpb       = tpb_round[LW +: WPB_W];
  assign rem       = tpb[LW-1:0];
  assign tail      = (rem == '0) ? '1 : ~({WARP{1'b1}} << rem);

  for (genvar s = 0; s < NUM_SM; s++) begin : g_room
    logic ret_ok;
    assign ret_ok     = blk_retire[s] && (blk_cnt[s] != '0);
    assign eff_blk[s] = blk_cnt[s] - BLK_W'(ret_ok);
    assign eff_thr[s] = thr_cnt[s] - (ret_ok ? THR_W'(tpb) : '0);
    assign fit[s]     = (int'(eff_blk[s]) < MAX_BLK) &&
                        (int'(eff_thr[s]) + int'(tpb) <= MAX_THR);
  end

  always_comb begin
    int idx;
    found = 1'b0;
    pick  = '0;
    no_resident = 1'b1;
    for (int i = 1; i <= NUM_SM; i++) begin
      idx = (int'(last_sm) + i) % NUM_SM;
      if (!found && fit[idx]) begin
        found = 1'b1;
        pick  = SM_W'(idx);
      end
    end
    for (int s = 0; s < NUM_SM; s++)
      if (blk_cnt[s] != '0) no_resident = 1'b0;
  end

  assign finished     = (next_bid == total) && no_resident && !asg_valid;
  assign launch_ready = !active || finished;
  assign grid_done    = active && finished;
  assign take         = launch_valid && launch_ready;
  assign admit        = active && (next_bid != total) &&
                        (!asg_valid || asg_ready) && found;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      total    <= '0;
      next_bid <= '0;
      tpb      <= '0;
      last_sm  <= SM_W'(NUM_SM - 1);
    end else if (take) begin
      active   <= 1'b1;
      total    <= launch_blocks;
      tpb      <= launch_tpb;
      next_bid <= '0;
    end else if (admit) begin
      next_bid <= next_bid + 1'b1;
      last_sm  <= pick;
    end
  end

  for (genvar s = 0; s < NUM_SM; s++) begin : g_cnt
    logic here;
    assign here = admit && (pick == SM_W'(s));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        blk_cnt[s] <= '0;
        thr_cnt[s] <= '0;
      end else begin
        blk_cnt[s] <= eff_blk[s] + BLK_W'(here);
        thr_cnt[s] <= eff_thr[s] + (here ? THR_W'(tpb) : '0);
      end
    end

    // R4
    blk_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(blk_cnt[s]) <= MAX_BLK);
    // R5
    thr_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(thr_cnt[s]) <= MAX_THR);
    // R7
    thr_blk_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(thr_cnt[s]) == int'(blk_cnt[s]) * int'(tpb));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asg_valid      <= 1'b0;
      asg_sm         <= '0;
      asg_block      <= '0;
      asg_warp_first <= '0;
      asg_warp_cnt   <= '0;
      asg_tail_mask  <= '0;
    end else if (admit) begin
      asg_valid      <= 1'b1;
      asg_sm         <= pick;
      asg_block      <= next_bid;
      asg_warp_first <= WID_W'(next_bid) * WID_W'(wpb);
      asg_warp_cnt   <= wpb;
      asg_tail_mask  <= tail;
    end else if (asg_ready) begin
      asg_valid      <= 1'b0;
    end
  end

  // R8
  rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asg_valid && !asg_ready |=> asg_valid && $stable(asg_block) && $stable(asg_sm)
                                && $stable(asg_tail_mask));
  // R6
  bid_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asg_valid && asg_ready |=> !asg_valid || asg_block == BID_W'($past(asg_block) + 1'b1));

endmodule

// File: tb/tb_blk_dispatch.sv
module tb_blk_dispatch;
  localparam int CLK_PERIOD = 10;
  localparam int NSM = 4;
  localparam int MBLK = 8;
  localparam int MTHR = 1536;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        launch_valid = 1'b0;
  logic        launch_ready;
  logic [11:0] launch_blocks = '0;
  logic [10:0] launch_tpb = '0;
  logic [NSM-1:0] blk_retire = '0;
  logic        asg_valid;
  logic        asg_ready = 1'b0;
  logic [1:0]  asg_sm;
  logic [11:0] asg_block;
  logic [17:0] asg_warp_first;
  logic [5:0]  asg_warp_cnt;
  logic [31:0] asg_tail_mask;
  logic        grid_done;

  blk_dispatch dut (
    .clk(clk), .rst_n(rst_n), .launch_valid(launch_valid), .launch_ready(launch_ready),
    .launch_blocks(launch_blocks), .launch_tpb(launch_tpb), .blk_retire(blk_retire),
    .asg_valid(asg_valid), .asg_ready(asg_ready), .asg_sm(asg_sm), .asg_block(asg_block),
    .asg_warp_first(asg_warp_first), .asg_warp_cnt(asg_warp_cnt),
    .asg_tail_mask(asg_tail_mask), .grid_done(grid_done));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int m_active, m_total, m_next, m_tpb, m_last, m_sm, m_bid;
  bit m_valid;
  int m_blk[NSM], m_thr[NSM];
  int obs[NSM];
  int rdy_pct = 100, ret_pct = 10;
  bit stray_en = 0;
  bit p_valid, p_ready;
  int p_sm, p_bid;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit model_fin();
    bit f;
    f = (m_next == m_total) && !m_valid;
    for (int s = 0; s < NSM; s++) if (m_blk[s] != 0) f = 0;
    return f;
  endfunction

  always @(posedge clk) begin
    int eb[NSM], et[NSM];
    int pick, c;
    bit fin, take, adm;
    if (!rst_n) begin
      m_active = 0; m_total = 0; m_next = 0; m_tpb = 0; m_last = NSM - 1;
      m_valid = 0; m_sm = 0; m_bid = 0;
      for (int s = 0; s < NSM; s++) begin m_blk[s] = 0; m_thr[s] = 0; end
    end else begin
      for (int s = 0; s < NSM; s++) begin
        if (blk_retire[s] && m_blk[s] > 0) begin
          eb[s] = m_blk[s] - 1; et[s] = m_thr[s] - m_tpb;
        end else begin
          eb[s] = m_blk[s]; et[s] = m_thr[s];
        end
      end
      fin  = model_fin();
      take = launch_valid && (!m_active || fin);
      pick = -1;
      for (int i = 1; i <= NSM; i++) begin
        c = (m_last + i) % NSM;
        if (pick < 0 && eb[c] < MBLK && et[c] + m_tpb <= MTHR) pick = c;
      end
      adm = m_active && m_next < m_total && (!m_valid || asg_ready) && pick >= 0;
      if (adm) begin eb[pick]++; et[pick] += m_tpb; end
      for (int s = 0; s < NSM; s++) begin m_blk[s] = eb[s]; m_thr[s] = et[s]; end
      if (adm) begin
        m_valid = 1; m_sm = pick; m_bid = m_next; m_next++; m_last = pick;
      end else if (asg_ready) m_valid = 0;
      if (take) begin
        m_active = 1; m_total = int'(launch_blocks); m_tpb = int'(launch_tpb); m_next = 0;
      end
    end
  end

  task automatic tick();
    int wpb, rem;
    logic [31:0] emask;
    bit fin;
    @(negedge clk);
    fin = model_fin();
    chk(launch_ready == (!m_active || fin), "R9 launch_ready", launch_ready, !m_active || fin);
    chk(grid_done == (m_active && fin), "R9 grid_done", grid_done, m_active && fin);
    chk(asg_valid == m_valid, "R6/R7/R10 asg_valid", asg_valid, m_valid);
    if (asg_valid && m_valid) begin
      wpb = (m_tpb + 31) / 32;
      rem = m_tpb % 32;
      emask = (rem == 0) ? 32'hffff_ffff : 32'((64'd1 << rem) - 1);
      chk(int'(asg_sm) == m_sm, "R6/R7 asg_sm", asg_sm, m_sm);
      chk(int'(asg_block) == m_bid, "R6 asg_block", asg_block, m_bid);
      chk(int'(asg_warp_cnt) == wpb, "R2 warp count", asg_warp_cnt, wpb);
      chk(int'(asg_warp_first) == m_bid * wpb, "R2 first warp", asg_warp_first, m_bid * wpb);
      chk(asg_tail_mask == emask, "R3 tail mask", asg_tail_mask, emask);
    end
    if (p_valid && !p_ready) begin
      chk(asg_valid && int'(asg_sm) == p_sm && int'(asg_block) == p_bid,
          "R8 held record", asg_block, p_bid);
    end
    blk_retire = '0;
    for (int s = 0; s < NSM; s++) begin
      if (obs[s] > 0 && ($urandom % 100) < ret_pct) begin
        blk_retire[s] = 1'b1; obs[s]--;
      end else if (stray_en && obs[s] == 0 && !(asg_valid && int'(asg_sm) == s)
                   && ($urandom % 8) == 0) begin
        blk_retire[s] = 1'b1; // R10 stray pulse
      end
    end
    asg_ready = (($urandom % 100) < rdy_pct);
    if (asg_valid && asg_ready) begin
      obs[asg_sm]++;
      chk(obs[asg_sm] <= MBLK, "R4 resident blocks", obs[asg_sm], MBLK);
      chk(obs[asg_sm] * m_tpb <= MTHR, "R5 resident threads", obs[asg_sm] * m_tpb, MTHR);
    end
    p_valid = asg_valid; p_ready = asg_ready; p_sm = int'(asg_sm); p_bid = int'(asg_block);
  endtask

  task automatic run_grid(input int nb, input int tpb, input int rdy, input int ret, input bit stray);
    int n;
    rdy_pct = rdy; ret_pct = ret; stray_en = stray;
    launch_valid = 1'b1; launch_blocks = 12'(nb); launch_tpb = 11'(tpb);
    tick();
    launch_valid = 1'b0;
    n = 0;
    tick();
    while (!grid_done && n < 20000) begin tick(); n++; end
    chk(grid_done == 1'b1, "R9 grid completes", grid_done, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < NSM; s++) obs[s] = 0;
    p_valid = 0; p_ready = 0; p_sm = 0; p_bid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(asg_valid == 1'b0, "R1 asg_valid", asg_valid, 0);
    chk(launch_ready == 1'b1, "R1 launch_ready", launch_ready, 1);
    chk(grid_done == 1'b0, "R1 grid_done", grid_done, 0);
    rst_n = 1'b1;
    run_grid(30, 256, 100, 3, 0);   // R5 six per slot
    run_grid(40, 64, 100, 3, 0);    // R4 eight per slot, 512 threads
    run_grid(12, 1024, 100, 20, 0); // R7 one per slot, retire and admit collide
    run_grid(16, 512, 60, 15, 0);   // R5 three per slot, R8 back-pressure
    run_grid(20, 33, 50, 10, 1);    // R3 one-lane tail, R10 stray pulses
    run_grid(9, 1, 70, 25, 1);      // R2 single-thread blocks
    run_grid(25, 100, 80, 12, 0);   // R3 four-lane tail
    run_grid(10, 1024, 40, 30, 1);  // R7 again under back-pressure
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule